// File: doc/BRIEF.md
# Address-Event Timestamping Receiver

This block sits between an asynchronous spike-address sender and a host-side buffer. The sender reports only which unit fired, as a row field and a column field, using a four-phase request/acknowledge handshake. The receiver brings the request into its clock domain and samples the address once it has settled. It then appends a local time marker, so that the address-only stream becomes a list of timestamped events. The list is accurate only if the delay from sender to receiver is constant.

The time marker is a 16-bit count of 20 µs ticks. A prescaler derives the tick from the system clock, and the count wraps silently. Each finished event leaves as one word on a valid/ready stream. When that stream stalls, the receiver withholds acknowledge, so the sender waits and no event is dropped. The stamp records when the request arrived, not when the word was accepted.

Top module: `aer_stamp_rx`

## Requirements
- R1: While reset is asserted and on leaving it, `ev_ack_o` and `out_valid_o` are low and `out_data_o` is zero.
- R2: Acknowledge rises on the fifth clock edge after the request rises, when the output slot is free: two synchroniser stages, detection, address capture, then load. It never rises while the synchronised request is low.
- R3: Once raised, acknowledge stays high as long as the request is held. It falls on the third clock edge after the request drops. No new event is detected until acknowledge has fallen.
- R4: The output word is {row[ROW_W-1:0], column[COL_W-1:0], stamp[TS_W-1:0]}, with the stamp in bits 15:0, the column in bits 18:16 and the row in bits 23:19 for the default widths. It becomes valid on the same edge that acknowledge rises.
- R5: The stamp counter advances by one every TICK_CYCLES clock cycles, counted from reset release. The default of 4000 gives 20 µs at 200 MHz. The stamp is the counter value held in the cycle the synchronised request is detected.
- R6: The stamp counter wraps from 0xFFFF to 0x0000 with no other effect.
- R7: While the output slot holds an unaccepted word, acknowledge for a new event is withheld. The event stays pending and is delivered once the slot frees.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the word stays unchanged. After an accepted transfer, `out_valid_o` is low on the next cycle unless a new word loads.
- R9: An event held back by a stall carries the stamp of its request's arrival, not of its delivery.
- R10: The address is sampled one cycle after detection. A value that changes during the first cycle after the request rises is captured in its final form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_req_i | input | 1 | Asynchronous event request from the sender |
| ev_row_i | input | ROW_W | Row field of the firing unit |
| ev_col_i | input | COL_W | Column field of the firing unit |
| ev_ack_o | output | 1 | Acknowledge to the sender, registered |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Host side accepts the word |
| out_data_o | output | ROW_W+COL_W+TS_W | Packed {row, column, stamp} |

## Verification
A fault in the handshake state shows directly at acknowledge. It appears as a wrong rise latency, an early fall while the request is still held, or a hang that the sender sees as a request never answered, all within a few cycles of the request edge. A fault in the capture or stamp registers appears in the next output word as a wrong field or an offset stamp. If the stamp were taken late, it would shift by the stall length, so one stalled event exposes it. A faulty prescaler or a faulty wrap shows up as an arithmetic mismatch with the bench's cycle count, at the latest near the 0xFFFF boundary.

// File: rtl/aer_rx_pkg.sv
package aer_rx_pkg;
  // handshake controller states
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // waiting for a synchronised request
    ST_SETTLE = 2'd1,  // request seen, stamp held, address settling
    ST_LOAD   = 2'd2,  // address held, waiting for a free output slot
    ST_ACKED  = 2'd3   // acknowledge high, waiting for request release
  } hs_state_t;
endpackage

// File: rtl/aer_bit_sync.sv
module aer_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/aer_tick_timer.sv
module aer_tick_timer #(
  parameter int TICK_CYCLES = 4000,
  parameter int TS_W        = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts_o
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [TS_W-1:0]  ts_q;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      ts_q  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) ts_q <= ts_q + 1'b1;  // silent wrap at the top
    end
  end

  assign ts_o = ts_q;

  // counter only moves on a prescaler tick
  assert_step_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ts_q));

  // all-ones rolls over to zero
  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && (&ts_q)) |=> (ts_q == '0));
endmodule

// File: rtl/aer_hs_ctrl.sv
module aer_hs_ctrl
  import aer_rx_pkg::*;
#(
  parameter int ROW_W = 5,
  parameter int COL_W = 3,
  parameter int TS_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_s_i,
  input  logic [ROW_W-1:0]            row_i,
  input  logic [COL_W-1:0]            col_i,
  input  logic [TS_W-1:0]             ts_i,
  output logic                        ack_o,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [ROW_W+COL_W+TS_W-1:0] out_data_o
);
  localparam int WORD_W = ROW_W + COL_W + TS_W;

  hs_state_t          state_q;
  logic               ack_q;
  logic               valid_q;
  logic [WORD_W-1:0]  data_q;
  logic [TS_W-1:0]    stamp_q;
  logic [ROW_W-1:0]   row_q;
  logic [COL_W-1:0]   col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      stamp_q <= '0;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      if (valid_q && out_ready_i) valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_s_i) begin
            stamp_q <= ts_i;          // time of arrival, not of departure
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          row_q   <= row_i;
          col_q   <= col_i;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!valid_q) begin         // back-pressure: no ack into a full slot
            data_q  <= {row_q, col_q, stamp_q};
            valid_q <= 1'b1;
            ack_q   <= 1'b1;
            state_q <= ST_ACKED;
          end
        end
        ST_ACKED: begin
          if (!req_s_i) begin
            ack_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o       = ack_q;
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  assert_ack_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> req_s_i);

  assert_ack_held_R3: assert property (@(posedge clk) disable iff (rst)
    (ack_q && req_s_i) |=> ack_q);

  assert_no_ack_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready_i) |=> !$rose(ack_q));

  assert_word_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !out_ready_i) |=> (valid_q && $stable(data_q)));
endmodule

// File: rtl/aer_stamp_rx.sv
module aer_stamp_rx #(
  parameter int ROW_W       = 5,
  parameter int COL_W       = 3,
  parameter int TS_W        = 16,
  parameter int TICK_CYCLES = 4000,  // 20 us at a 200 MHz clock
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ev_req_i,
  input  logic [ROW_W-1:0]            ev_row_i,
  input  logic [COL_W-1:0]            ev_col_i,
  output logic                        ev_ack_o,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [ROW_W+COL_W+TS_W-1:0] out_data_o
);
  logic            req_s;
  logic [TS_W-1:0] ts_now;

  aer_bit_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
    .clk (clk),
    .rst (rst),
    .d_i (ev_req_i),
    .q_o (req_s)
  );

  aer_tick_timer #(.TICK_CYCLES(TICK_CYCLES), .TS_W(TS_W)) timer_i (
    .clk  (clk),
    .rst  (rst),
    .ts_o (ts_now)
  );

  aer_hs_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .TS_W(TS_W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .req_s_i     (req_s),
    .row_i       (ev_row_i),
    .col_i       (ev_col_i),
    .ts_i        (ts_now),
    .ack_o       (ev_ack_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o)
  );
endmodule

// File: tb/aer_stamp_rx_tb_top.sv
`timescale 1ns/1ps
module aer_stamp_rx_tb_top;
  localparam int RW = 5;
  localparam int CW = 3;
  localparam int TW = 16;
  localparam int TICK = 2;  // short tick so the wrap is reachable

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_req = 1'b0;
  logic [RW-1:0] ev_row = '0;
  logic [CW-1:0] ev_col = '0;
  logic          ev_ack;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [RW+CW+TW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  aer_stamp_rx #(.ROW_W(RW), .COL_W(CW), .TS_W(TW), .TICK_CYCLES(TICK)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .ev_req_i    (ev_req),
    .ev_row_i    (ev_row),
    .ev_col_i    (ev_col),
    .ev_ack_o    (ev_ack),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // stamp held in the detection cycle: request raised after cyc=c edges
  function automatic logic [TW-1:0] exp_ts(input int c);
    return TW'(((c + 2) / TICK) % 65536);
  endfunction

  task automatic release_req();
    int lat;
    ev_req = 1'b0;
    lat = 0;
    while (ev_ack && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == 3, "R3 ack fall latency", 32'(lat), 32'd3);
  endtask

  // one full event with the output always ready
  task automatic do_event(input logic [RW-1:0] r, input logic [CW-1:0] cl,
                          input bit garbage, output logic [TW-1:0] got_ts);
    int c, lat;
    @(negedge clk);
    ev_row = garbage ? ~r : r;
    ev_col = garbage ? ~cl : cl;
    ev_req = 1'b1;
    c = cyc;
    lat = 0;
    if (garbage) begin
      @(negedge clk); lat = 1; ev_row = r; ev_col = cl;
    end
    while (!ev_ack && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == 5, "R2 ack rise latency", 32'(lat), 32'd5);
    chk(out_valid == 1'b1, "R4 valid with ack", 32'(out_valid), 32'd1);
    chk(out_data == {r, cl, exp_ts(c)}, garbage ? "R10 settled address" : "R4 R5 word",
        32'(out_data), 32'({r, cl, exp_ts(c)}));
    got_ts = out_data[TW-1:0];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(ev_ack == 1'b1, "R3 ack held", 32'(ev_ack), 32'd1);
    end
    release_req();
  endtask

  task automatic t_reset();
    chk(ev_ack == 1'b0, "R1 ack reset", 32'(ev_ack), 32'd0);
    chk(out_valid == 1'b0, "R1 valid reset", 32'(out_valid), 32'd0);
    chk(out_data == '0, "R1 data reset", 32'(out_data), 32'd0);
  endtask

  task automatic t_basic();
    logic [TW-1:0] t;
    do_event(5'd0,  3'd0, 1'b0, t);
    do_event(5'd31, 3'd7, 1'b0, t);
    do_event(5'd21, 3'd5, 1'b0, t);
    do_event(5'd10, 3'd2, 1'b0, t);
  endtask

  task automatic t_settle();
    logic [TW-1:0] t;
    do_event(5'd19, 3'd6, 1'b1, t);  // R10
  endtask

  task automatic t_stall();
    int ca, cb, lat;
    bit ack_seen, word_moved;
    logic [RW+CW+TW-1:0] wa, wb;
    out_ready = 1'b0;
    @(negedge clk);
    ev_row = 5'd3; ev_col = 3'd1; ev_req = 1'b1; ca = cyc;
    lat = 0;
    while (!ev_ack && lat < 40) begin @(negedge clk); lat++; end
    wa = {5'd3, 3'd1, exp_ts(ca)};
    chk(out_data == wa, "R4 stalled first word", 32'(out_data), 32'(wa));
    release_req();
    @(negedge clk);
    ev_row = 5'd27; ev_col = 3'd4; ev_req = 1'b1; cb = cyc;
    ack_seen = 1'b0; word_moved = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ev_ack) ack_seen = 1'b1;
      if (!out_valid || out_data != wa) word_moved = 1'b1;
    end
    chk(!ack_seen, "R7 ack withheld", 32'(ack_seen), 32'd0);
    chk(!word_moved, "R8 word held", 32'(word_moved), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 valid drops", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk(ev_ack == 1'b1, "R7 pending event acked", 32'(ev_ack), 32'd1);
    wb = {5'd27, 3'd4, exp_ts(cb)};
    chk(out_data == wb, "R9 arrival stamp", 32'(out_data), 32'(wb));
    release_req();
  endtask

  task automatic t_wrap();
    logic [TW-1:0] t;
    while (cyc < 131067) @(negedge clk);
    do_event(5'd1, 3'd1, 1'b0, t);
    chk(t == 16'hFFFF, "R6 top value", 32'(t), 32'hFFFF);
    do_event(5'd2, 3'd2, 1'b0, t);
    chk(t < 16'd64, "R6 wrapped low", 32'(t), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_settle();
    t_stall();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule